// File: doc/BRIEF.md
# Reset Vector Redirect and Bus Phantom Controller

This block sits beside the address decoder of a memory board that holds two relocatable address regions. After a reset, the processor fetches its first instruction from address 0x0000. The block makes the board answer that fetch from the first bytes of one of its own regions. It does this by raising an override select and supplying an offset into the target region, which the region decoder uses in place of its normal match. While the override is armed, the block also pulls an active-low phantom line that tells every other memory board on the bus to stay silent.

The override stays armed across the reset pulse and after it. It is released by the first memory access, made after reset has gone inactive, whose high address bits fall inside the target region's own window. That access is normally the fetch that follows the jump stored at the region start. The low address bits pass straight through, so a multi-byte jump opcode at 0x0000–0x0002 is read from the region's first bytes.

Four static configuration inputs shape the block. One selects which reset line arms it. One chooses the target region through the same swap input that exchanges the two region bases. The last two disable the phantom output and the on-board response independently. A new reset on the selected line re-arms the block at any time.

Top module: `rstvec_redirect`

## Requirements
- R1: When `cfg_use_preset` is 1, only a low level on `preset_n` arms the block and `poc_n` has no effect. When it is 0, only a low `poc_n` arms it and `preset_n` has no effect.
- R2: While the block is active (the selected reset is low or the block is armed) and `cfg_jump_en` is 1, an address whose top SEL_W bits are zero drives `ovr_sel` to 1 in the same cycle, with `ovr_offset` equal to the address's low ADDR_W-SEL_W bits. Any other address gives `ovr_sel` = 0.
- R3: `ovr_region` equals `cfg_swap`, where 0 means the second region (base `base_b`) and 1 means the first region (base `base_a`). The release window is the base of that selected region.
- R4: While the block is active and `cfg_phantom_en` is 1, `phantom_n` is 0. This holds combinationally during the reset pulse as well.
- R5: A cycle with `bus_access` = 1, the selected reset high, and address top bits equal to the target base clears the armed state at that clock edge. From the next cycle on, `phantom_n` is 1 and `ovr_sel` is 0.
- R6: With `cfg_phantom_en` = 0, `phantom_n` stays 1 at all times.
- R7: With `cfg_jump_en` = 0, `ovr_sel` stays 0 at all times.
- R8: A low level on the selected reset arms the block at the next clock edge, whether or not it was armed before. Arming persists after the reset returns high.
- R9: While armed, accesses whose top address bits differ from the target base, and cycles without `bus_access`, leave the block armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| poc_n | input | 1 | Power-on-clear reset, active low |
| preset_n | input | 1 | Preset reset, active low |
| cfg_use_preset | input | 1 | 1: preset_n arms the block; 0: poc_n arms it |
| cfg_phantom_en | input | 1 | Enables the phantom output |
| cfg_jump_en | input | 1 | Enables the on-board answer at 0x0000 |
| cfg_swap | input | 1 | Region swap; also picks the target region |
| base_a | input | SEL_W | Window of the first region |
| base_b | input | SEL_W | Window of the second region |
| bus_addr | input | ADDR_W | Bus address |
| bus_access | input | 1 | A memory access is under way this cycle |
| phantom_n | output | 1 | Phantom line, active low |
| ovr_sel | output | 1 | Forces the target region to respond |
| ovr_region | output | 1 | Target region: 0 second, 1 first |
| ovr_offset | output | ADDR_W-SEL_W | Offset into the target region |

## Verification
The redirect is driven with fetches at 0x0000, 0x0001 and 0x0002 and at an address outside the low window. This shows that the low bits pass through and that only the lowest window is redirected. Accesses to the low window, to a foreign window and to the target window show that only the target window releases the block. The swap case moves the target window to the other base, which confirms the release follows the selected region and not a fixed one. Pulses on the unselected reset line, together with runs that have each enable cleared, separate trigger selection from the phantom and jump gating.

// File: rtl/rstvec_redirect.sv
module rstvec_redirect #(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 3
) (
  input  logic                    clk,
  input  logic                    poc_n,
  input  logic                    preset_n,
  input  logic                    cfg_use_preset,
  input  logic                    cfg_phantom_en,
  input  logic                    cfg_jump_en,
  input  logic                    cfg_swap,
  input  logic [SEL_W-1:0]        base_a,
  input  logic [SEL_W-1:0]        base_b,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_access,
  output logic                    phantom_n,
  output logic                    ovr_sel,
  output logic                    ovr_region,
  output logic [ADDR_W-SEL_W-1:0] ovr_offset
);
  localparam int OFS_W = ADDR_W - SEL_W;

  logic             trig_act;
  logic             armed_q;
  logic             active;
  logic [SEL_W-1:0] hi;
  logic [SEL_W-1:0] tgt_base;
  logic             hit_tgt;

  assign trig_act = cfg_use_preset ? !preset_n : !poc_n;
  assign hi       = bus_addr[ADDR_W-1:OFS_W];
  assign tgt_base = cfg_swap ? base_a : base_b;
  assign hit_tgt  = bus_access && !trig_act && (hi == tgt_base);
  assign active   = trig_act || armed_q;

  always_ff @(posedge clk) begin
    if (trig_act)
      armed_q <= 1'b1;
    else if (hit_tgt)
      armed_q <= 1'b0;
  end

  assign phantom_n  = !(active && cfg_phantom_en);
  assign ovr_sel    = active && cfg_jump_en && (hi == '0);
  assign ovr_region = cfg_swap;
  assign ovr_offset = bus_addr[OFS_W-1:0];

  // R8
  arm_on_trig_chk: assert property (@(posedge clk)
    trig_act |=> (armed_q || !trig_act) && (trig_act || armed_q));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (trig_act)
    (armed_q && hit_tgt) |=> !armed_q);

  // R9
  hold_armed_chk: assert property (@(posedge clk) disable iff (trig_act)
    (armed_q && !(bus_access && hi == tgt_base)) |=> armed_q);

  // R6
  phantom_off_chk: assert property (@(posedge clk) disable iff (trig_act)
    !cfg_phantom_en |-> phantom_n);

  // R7
  jump_off_chk: assert property (@(posedge clk) disable iff (trig_act)
    !cfg_jump_en |-> !ovr_sel);

  // R2
  low_window_chk: assert property (@(posedge clk) disable iff (trig_act)
    ovr_sel |-> (hi == '0) && armed_q);
endmodule

// File: tb/rstvec_redirect_tb.sv
module rstvec_redirect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int SEL_W  = 3;
  localparam int OFS_W  = ADDR_W - SEL_W;

  logic clk = 1'b0;
  logic poc_n = 1'b0, preset_n = 1'b1;
  logic cfg_use_preset = 1'b0, cfg_phantom_en = 1'b1, cfg_jump_en = 1'b1, cfg_swap = 1'b0;
  logic [SEL_W-1:0] base_a = 3'd2, base_b = 3'd6;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_access = 1'b0;
  logic phantom_n, ovr_sel, ovr_region;
  logic [OFS_W-1:0] ovr_offset;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstvec_redirect #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) dut_i (
    .clk(clk), .poc_n(poc_n), .preset_n(preset_n),
    .cfg_use_preset(cfg_use_preset), .cfg_phantom_en(cfg_phantom_en),
    .cfg_jump_en(cfg_jump_en), .cfg_swap(cfg_swap),
    .base_a(base_a), .base_b(base_b), .bus_addr(bus_addr), .bus_access(bus_access),
    .phantom_n(phantom_n), .ovr_sel(ovr_sel), .ovr_region(ovr_region), .ovr_offset(ovr_offset));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); bus_access = 0; bus_addr = 16'h4000; #1;
  endtask

  task automatic access(logic [ADDR_W-1:0] a);
    @(negedge clk); bus_access = 1; bus_addr = a; #1;
    @(negedge clk); bus_access = 0; bus_addr = 16'h4000; #1;
  endtask

  task automatic peek0();
    bus_addr = 16'h0000; #1;
  endtask

  task automatic t_reset();
    @(negedge clk); peek0();
    chk("R4", "phantom during poc", phantom_n, 0);
    chk("R2", "sel at 0 during poc", ovr_sel, 1);
    chk("R3", "default region", ovr_region, 0);
    @(negedge clk); poc_n = 1; #1; idle();
  endtask

  task automatic t_map();
    @(negedge clk); bus_access = 1;
    bus_addr = 16'h0000; #1;
    chk("R2", "sel 0000", ovr_sel, 1); chk("R2", "ofs 0000", ovr_offset, 0);
    bus_addr = 16'h0001; #1;
    chk("R2", "ofs 0001", ovr_offset, 1);
    bus_addr = 16'h0002; #1;
    chk("R2", "ofs 0002", ovr_offset, 2);
    bus_addr = 16'h4000; #1;
    chk("R2", "sel outside low window", ovr_sel, 0);
    idle();
    chk("R9", "armed after low-window fetches", phantom_n, 0);
    access(16'hA000);
    chk("R9", "armed after foreign access", phantom_n, 0);
  endtask

  task automatic t_release();
    access(16'hC000);
    chk("R5", "phantom released", phantom_n, 1);
    peek0();
    chk("R5", "no sel after release", ovr_sel, 0);
  endtask

  task automatic t_rearm();
    @(negedge clk); poc_n = 0; #1;
    chk("R4", "phantom during re-arm pulse", phantom_n, 0);
    @(negedge clk); poc_n = 1; #1;
    idle(); idle();
    chk("R8", "armed after pulse", phantom_n, 0);
    peek0();
    chk("R8", "sel after pulse", ovr_sel, 1);
    access(16'hC000);
  endtask

  task automatic t_trigsel();
    @(negedge clk); cfg_use_preset = 1; #1;
    @(negedge clk); poc_n = 0; #1;
    chk("R1", "poc ignored comb", phantom_n, 1);
    @(negedge clk); poc_n = 1; #1; idle();
    chk("R1", "poc ignored after", phantom_n, 1);
    @(negedge clk); preset_n = 0; #1;
    chk("R1", "preset arms comb", phantom_n, 0);
    @(negedge clk); preset_n = 1; #1; idle();
    chk("R1", "preset arms after", phantom_n, 0);
    access(16'hC000);
    chk("R5", "release in preset mode", phantom_n, 1);
    @(negedge clk); cfg_use_preset = 0; #1;
    @(negedge clk); preset_n = 0; #1;
    chk("R1", "preset ignored", phantom_n, 1);
    @(negedge clk); preset_n = 1; #1; idle();
  endtask

  task automatic t_swap();
    @(negedge clk); cfg_swap = 1; poc_n = 0; #1;
    chk("R3", "region after swap", ovr_region, 1);
    @(negedge clk); poc_n = 1; #1;
    access(16'hC000);
    chk("R3", "other base does not release", phantom_n, 0);
    access(16'h4000);
    chk("R3", "swapped base releases", phantom_n, 1);
    @(negedge clk); cfg_swap = 0; #1;
  endtask

  task automatic t_phantom_dis();
    @(negedge clk); cfg_phantom_en = 0; poc_n = 0; #1;
    chk("R6", "no phantom in reset", phantom_n, 1);
    @(negedge clk); poc_n = 1; #1; idle(); peek0();
    chk("R6", "no phantom armed", phantom_n, 1);
    chk("R2", "sel with phantom off", ovr_sel, 1);
    access(16'hC000);
    @(negedge clk); cfg_phantom_en = 1; #1;
  endtask

  task automatic t_jump_dis();
    @(negedge clk); cfg_jump_en = 0; poc_n = 0; #1; peek0();
    chk("R7", "no sel in reset", ovr_sel, 0);
    @(negedge clk); poc_n = 1; #1; idle(); peek0();
    chk("R7", "no sel armed", ovr_sel, 0);
    chk("R4", "phantom with jump off", phantom_n, 0);
    access(16'hC000);
    @(negedge clk); cfg_jump_en = 1; #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_map();
    t_release();
    t_rearm();
    t_trigsel();
    t_swap();
    t_phantom_dis();
    t_jump_dis();
    finish_run();
  end
endmodule